// File: doc/BRIEF.md
# SPI Flash Status Auto-Poller

This block takes the chore of waiting on a SPI memory off the processor. After a start pulse it waits for a programmable initial delay. It then reads the device status register over a single-lane SPI link, using mode 0 and MSB-first order, and compares each status word with a mask and an expected pattern. Between reads it waits for a programmable interval. It stops on a match, on a bus fault during a read, or when a timeout counted from start has run out. Each outcome is reported as a result code with a one-cycle done pulse.

A match also sets a sticky flag. This flag stays set across runs until software writes a one to the clear input. An interrupt line shows the flag while the interrupt enable is set. The auto-stop control selects what happens after a match. With auto-stop on, the run ends at the first match. With auto-stop off, polling continues until the timeout and the flag stays set. Delays, the interval and the timeout are counted in ticks of an internal prescaler, and each start restarts the prescaler. Every port is a plain control or status pin. No part of the block streams data, so no port carries a valid/ready handshake and no back-pressure applies.

Result codes: 0 = matched, 1 = timeout, 2 = invalid configuration, 3 = read fault.

Top module: `status_poller`

## Requirements
- R1: After reset, spi_cs_n is high, spi_sclk is low, and busy, done, match_flag and irq are all low.
- R2: When a start arrives while idle, it is checked. If cfg_len is not 1 or 2, or cfg_dir_in is low, done pulses one cycle later with result 2. In that case busy never rises and spi_cs_n never falls.
- R3: Each status read holds spi_cs_n low while it shifts the opcode out MSB first on spi_mosi, then clocks in cfg_len status bytes. spi_mosi changes while spi_sclk is low, and spi_miso is sampled on the rising edge. With 2 bytes, the first byte received forms bits 15:8. With 1 byte, the value sits in bits 7:0 and bits 15:8 read zero. status_out holds the value of the latest read.
- R4: A read matches when (status AND cfg_mask) equals cfg_match. A match sets match_flag. With cfg_auto_stop high, the run ends after that read with result 0.
- R5: The first spi_cs_n fall comes no sooner than cfg_init_dly*TICK_DIV clock cycles after start.
- R6: Between reads, spi_cs_n stays high for at least one SCLK period plus (cfg_interval-1)*TICK_DIV clock cycles.
- R7: If cfg_timeout ticks pass from start without a match, the run ends with result 1. The run never ends earlier than cfg_timeout*TICK_DIV cycles, and a read in progress always completes first.
- R8: With cfg_auto_stop low, reads continue after a match until the timeout. The run then ends with result 0 and match_flag stays set.
- R9: match_flag is sticky. A one-cycle pulse on match_clr clears it, and a new match in the same cycle takes priority over the clear.
- R10: irq is high exactly when match_flag and irq_en are both high.
- R11: If xfer_fault is high during a read, the run ends when that read completes, with result 3, and no further read is made.
- R12: A start while busy is ignored, including any new configuration. done lasts one cycle, and busy falls in the same cycle that done rises.
- R13: Each SCLK high phase and each low phase lasts cfg_half_div clock cycles. A value of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, taken only while idle |
| cfg_opcode | input | 8 | Status-read opcode |
| cfg_len | input | 2 | Status length in bytes (1 or 2) |
| cfg_dir_in | input | 1 | High for device-to-host data, required |
| cfg_mask | input | 16 | Status bit mask |
| cfg_match | input | 16 | Expected masked status |
| cfg_init_dly | input | CW | Initial delay in ticks |
| cfg_interval | input | CW | Interval between reads in ticks |
| cfg_timeout | input | CW | Timeout in ticks from start |
| cfg_half_div | input | DIVW | SCLK half period in clock cycles |
| cfg_auto_stop | input | 1 | Stop on first match |
| irq_en | input | 1 | Match interrupt enable |
| match_clr | input | 1 | Write-1 clear of match_flag |
| xfer_fault | input | 1 | Marks the read in progress as failed |
| spi_miso | input | 1 | SPI data from device |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | Result code of the last run |
| status_out | output | 16 | Latest assembled status |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Match interrupt |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to device |

## Verification
The bench builds the block with TICK_DIV=4, CW=12 and DIVW=4. With a four-cycle tick, timeouts of 50 to 100 ticks expire within a few hundred cycles. This makes it practical to run timeout, non-stopping and ignored-start cases back to back. It also lets the bench check the initial-delay and interval lower bounds as exact cycle counts. The 4-bit divider allows half periods of 1 and 3 cycles, which covers both the fastest SCLK and a stretched one.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_TIMEOUT  = 2'd1,
    RES_INVALID  = 2'd2,
    RES_XFER_ERR = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_XFER,
    ST_GUARD,
    ST_GAP
  } st_e;

  typedef struct packed {
    logic [7:0]  opcode;
    logic        two_byte;
    logic [15:0] mask;
    logic [15:0] match;
    logic        auto_stop;
  } job_t;
endpackage

// File: rtl/poll_tick.sv
module poll_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr || cnt == LAST)    cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !clr;

  generate
    if (DIV > 1) begin : g_spacing
      // R5: ticks never come back to back when the divider is above one
      assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/poll_spi_xfer.sv
module poll_spi_xfer #(
  parameter int unsigned DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [7:0]      opcode,
  input  logic            two_byte,
  input  logic [DIVW-1:0] half_div,
  input  logic            miso,
  output logic            sclk,
  output logic            cs_n,
  output logic            mosi,
  output logic            done,
  output logic [15:0]     rx_word
);
  logic            active;
  logic            two_q;
  logic [DIVW-1:0] hcnt;
  logic [DIVW-1:0] half_eff;
  logic [4:0]      bitcnt;
  logic [4:0]      last_bit;
  logic [23:0]     tx;
  logic [15:0]     rx;

  assign half_eff = (half_div == '0) ? DIVW'(1) : half_div;
  assign last_bit = two_q ? 5'd23 : 5'd15;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0; mosi <= 1'b0;
      done <= 1'b0; hcnt <= '0; bitcnt <= '0; tx <= '0; rx <= '0; two_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1; cs_n <= 1'b0; sclk <= 1'b0;
          hcnt <= '0; bitcnt <= '0;
          tx <= {opcode, 16'h0000}; mosi <= opcode[7];
          two_q <= two_byte; rx <= '0;
        end
      end else if (hcnt == half_eff - DIVW'(1)) begin
        hcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[14:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitcnt == last_bit) begin
            active <= 1'b0; cs_n <= 1'b1; done <= 1'b1; mosi <= 1'b0;
          end else begin
            bitcnt <= bitcnt + 5'd1;
            tx     <= {tx[22:0], 1'b0};
            mosi   <= tx[22];
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assign rx_word = two_q ? rx : {8'h00, rx[7:0]};

  // R13: clock parked low while deselected
  assert_sclk_parked_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R3: completion pulse only once the device is released
  assert_done_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_pkg::*;
#(
  parameter int unsigned CW   = 16,
  parameter int unsigned DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      cfg_opcode,
  input  logic [1:0]      cfg_len,
  input  logic            cfg_dir_in,
  input  logic [15:0]     cfg_mask,
  input  logic [15:0]     cfg_match,
  input  logic [CW-1:0]   cfg_init_dly,
  input  logic [CW-1:0]   cfg_interval,
  input  logic [CW-1:0]   cfg_timeout,
  input  logic [DIVW-1:0] cfg_half_div,
  input  logic            cfg_auto_stop,
  input  logic            match_clr,
  input  logic            xfer_fault,
  input  logic            tick,
  input  logic            eng_done,
  input  logic [15:0]     eng_data,
  output logic            tick_clr,
  output logic            go,
  output logic [7:0]      job_opcode,
  output logic            job_two_byte,
  output logic [DIVW-1:0] job_half,
  output logic            busy,
  output logic            done,
  output logic [1:0]      result,
  output logic [15:0]     status_out,
  output logic            match_flag
);
  localparam int unsigned GW = DIVW + 1;

  st_e             st;
  job_t            job;
  res_e            res_q, fin_res, end_res;
  logic [CW-1:0]   init_q, int_q, tmo_q, dcnt, tcnt;
  logic [DIVW-1:0] half_q, half_eff;
  logic [GW-1:0]   gcnt, guard_last;
  logic            seen_q, fault_q;
  logic            valid, expired, hit;
  logic            fin, to_xfer, to_guard, set_match;

  assign valid      = (cfg_len == 2'd1 || cfg_len == 2'd2) && cfg_dir_in;
  assign tick_clr   = start && (st == ST_IDLE);
  assign expired    = (tcnt >= tmo_q);
  assign hit        = ((eng_data & job.mask) == job.match);
  assign half_eff   = (half_q == '0) ? DIVW'(1) : half_q;
  assign guard_last = ({1'b0, half_eff} << 1) - GW'(1);
  assign end_res    = seen_q ? RES_OK : RES_TIMEOUT;

  always_comb begin
    fin = 1'b0; fin_res = RES_OK; to_xfer = 1'b0; to_guard = 1'b0; set_match = 1'b0;
    case (st)
      ST_INIT, ST_GAP: begin
        if (expired) begin
          fin = 1'b1; fin_res = end_res;
        end else if (dcnt >= ((st == ST_INIT) ? init_q : int_q)) begin
          to_xfer = 1'b1;
        end
      end
      ST_XFER: begin
        if (eng_done) begin
          if (fault_q || xfer_fault) begin
            fin = 1'b1; fin_res = RES_XFER_ERR;
          end else if (hit) begin
            set_match = 1'b1;
            if (job.auto_stop || expired) begin fin = 1'b1; fin_res = RES_OK; end
            else to_guard = 1'b1;
          end else if (expired) begin
            fin = 1'b1; fin_res = end_res;
          end else begin
            to_guard = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; job <= '0; res_q <= RES_OK;
      init_q <= '0; int_q <= '0; tmo_q <= '0; dcnt <= '0; tcnt <= '0;
      half_q <= '0; gcnt <= '0; seen_q <= 1'b0; fault_q <= 1'b0;
      busy <= 1'b0; done <= 1'b0; go <= 1'b0; status_out <= '0; match_flag <= 1'b0;
    end else begin
      done <= 1'b0;
      go   <= 1'b0;
      if (set_match)      match_flag <= 1'b1;
      else if (match_clr) match_flag <= 1'b0;
      if (st != ST_IDLE && tick && tcnt != '1) tcnt <= tcnt + 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          job <= '{opcode: cfg_opcode, two_byte: (cfg_len == 2'd2), mask: cfg_mask,
                   match: cfg_match, auto_stop: cfg_auto_stop};
          init_q <= cfg_init_dly; int_q <= cfg_interval; tmo_q <= cfg_timeout;
          half_q <= cfg_half_div;
          if (!valid) begin
            done <= 1'b1; res_q <= RES_INVALID;
          end else begin
            st <= ST_INIT; busy <= 1'b1; dcnt <= '0; tcnt <= '0; seen_q <= 1'b0;
          end
        end
        ST_INIT, ST_GAP: if (!fin && !to_xfer && tick) dcnt <= dcnt + 1'b1;
        ST_GUARD: begin
          if (gcnt == guard_last) begin st <= ST_GAP; dcnt <= '0; end
          else gcnt <= gcnt + 1'b1;
        end
        ST_XFER: begin
          if (xfer_fault) fault_q <= 1'b1;
          if (eng_done)   status_out <= eng_data;
        end
        default: st <= ST_IDLE;
      endcase
      if (to_xfer)   begin st <= ST_XFER; go <= 1'b1; fault_q <= 1'b0; end
      if (to_guard)  begin st <= ST_GUARD; gcnt <= '0; end
      if (set_match) seen_q <= 1'b1;
      if (fin)       begin st <= ST_IDLE; busy <= 1'b0; done <= 1'b1; res_q <= fin_res; end
    end
  end

  assign result       = res_q;
  assign job_opcode   = job.opcode;
  assign job_two_byte = job.two_byte;
  assign job_half     = half_q;

  // R12: busy is already low in the done cycle
  assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R12: a start during a run leaves the captured job untouched
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(job));
  // R2: a bad configuration is answered at once with the invalid code
  assert_invalid_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !valid) |=> (done && !busy && result == RES_INVALID));
  // R9: flag holds unless cleared
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);
  // R9: a falling flag always follows a clear request
  assert_flag_clear_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(match_flag) |-> $past(match_clr));
endmodule

// File: rtl/status_poller.sv
module status_poller
  import poll_pkg::*;
#(
  parameter int unsigned TICK_DIV = 100,
  parameter int unsigned CW       = 16,
  parameter int unsigned DIVW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      cfg_opcode,
  input  logic [1:0]      cfg_len,
  input  logic            cfg_dir_in,
  input  logic [15:0]     cfg_mask,
  input  logic [15:0]     cfg_match,
  input  logic [CW-1:0]   cfg_init_dly,
  input  logic [CW-1:0]   cfg_interval,
  input  logic [CW-1:0]   cfg_timeout,
  input  logic [DIVW-1:0] cfg_half_div,
  input  logic            cfg_auto_stop,
  input  logic            irq_en,
  input  logic            match_clr,
  input  logic            xfer_fault,
  input  logic            spi_miso,
  output logic            busy,
  output logic            done,
  output logic [1:0]      result,
  output logic [15:0]     status_out,
  output logic            match_flag,
  output logic            irq,
  output logic            spi_sclk,
  output logic            spi_cs_n,
  output logic            spi_mosi
);
  logic            tick, tick_clr, go, eng_done, job_two_byte;
  logic [7:0]      job_opcode;
  logic [DIVW-1:0] job_half;
  logic [15:0]     eng_data;

  poll_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick));

  poll_ctrl #(.CW(CW), .DIVW(DIVW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_opcode(cfg_opcode), .cfg_len(cfg_len), .cfg_dir_in(cfg_dir_in),
    .cfg_mask(cfg_mask), .cfg_match(cfg_match), .cfg_init_dly(cfg_init_dly),
    .cfg_interval(cfg_interval), .cfg_timeout(cfg_timeout), .cfg_half_div(cfg_half_div),
    .cfg_auto_stop(cfg_auto_stop), .match_clr(match_clr), .xfer_fault(xfer_fault),
    .tick(tick), .eng_done(eng_done), .eng_data(eng_data),
    .tick_clr(tick_clr), .go(go), .job_opcode(job_opcode), .job_two_byte(job_two_byte),
    .job_half(job_half), .busy(busy), .done(done), .result(result),
    .status_out(status_out), .match_flag(match_flag));

  poll_spi_xfer #(.DIVW(DIVW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .go(go), .opcode(job_opcode), .two_byte(job_two_byte),
    .half_div(job_half), .miso(spi_miso), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .done(eng_done), .rx_word(eng_data));

  assign irq = match_flag & irq_en;

  // R3: the device is selected only inside a run
  assert_cs_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  // R2: a select edge never starts outside a run
  assert_cs_fall_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> busy);
endmodule

// File: tb/status_poller_bench.sv
`timescale 1ns/1ps
module status_poller_bench;
  localparam int unsigned TICK_DIV = 4;
  localparam int unsigned CW = 12;
  localparam int unsigned DIVW = 4;

  typedef struct {
    logic [1:0]  res;
    bit          chk_st;
    logic [15:0] st;
    logic        flag;
    int          minr;
    int          maxr;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] cfg_opcode = 8'h05;
  logic [1:0] cfg_len = 2'd1;
  logic cfg_dir_in = 1'b1, cfg_auto_stop = 1'b1, irq_en = 1'b0, match_clr = 1'b0, xfer_fault = 1'b0;
  logic [15:0] cfg_mask = '0, cfg_match = '0;
  logic [CW-1:0] cfg_init_dly = '0, cfg_interval = '0, cfg_timeout = '0;
  logic [DIVW-1:0] cfg_half_div = 4'd1;
  logic spi_miso = 1'b0;
  logic busy, done, match_flag, irq, spi_sclk, spi_cs_n, spi_mosi;
  logic [1:0] result;
  logic [15:0] status_out;

  status_poller #(.TICK_DIV(TICK_DIV), .CW(CW), .DIVW(DIVW)) u_status_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_opcode(cfg_opcode), .cfg_len(cfg_len),
    .cfg_dir_in(cfg_dir_in), .cfg_mask(cfg_mask), .cfg_match(cfg_match),
    .cfg_init_dly(cfg_init_dly), .cfg_interval(cfg_interval), .cfg_timeout(cfg_timeout),
    .cfg_half_div(cfg_half_div), .cfg_auto_stop(cfg_auto_stop), .irq_en(irq_en),
    .match_clr(match_clr), .xfer_fault(xfer_fault), .spi_miso(spi_miso), .busy(busy),
    .done(done), .result(result), .status_out(status_out), .match_flag(match_flag),
    .irq(irq), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  exp_t exp_q[$];
  int done_cnt = 0;
  longint done_cyc = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // device model
  logic [15:0] resp_q[$];
  logic [15:0] dflt_resp = 16'h0001, cur_resp = '0;
  int dev_len = 1, rise_n = 0, reads_cnt = 0;
  logic [7:0] op_cap = '0, exp_op = 8'h05;
  longint start_cyc = 0, first_fall = 0, last_rise = 0, min_gap = 0, hi_t = 0, hi_min = 0, hi_max = 0;

  function automatic logic bit_at(int b);
    int k;
    if (b < 8) return 1'b0;
    k = b - 8;
    if (dev_len == 2) return (k < 16) ? cur_resp[15-k] : 1'b0;
    return (k < 8) ? cur_resp[7-k] : 1'b0;
  endfunction

  always @(negedge spi_cs_n) begin
    reads_cnt++;
    rise_n = 0;
    op_cap = '0;
    cur_resp = (resp_q.size() > 0) ? resp_q.pop_front() : dflt_resp;
    spi_miso = bit_at(0);
    if (reads_cnt == 1) first_fall = cyc - start_cyc;
    else if (min_gap == 0 || cyc - last_rise < min_gap) min_gap = cyc - last_rise;
  end
  always @(posedge spi_cs_n) last_rise = cyc;
  always @(posedge spi_sclk) begin
    if (rise_n < 8) op_cap = {op_cap[6:0], spi_mosi};
    rise_n++;
    hi_t = cyc;
    if (rise_n == 8) check(op_cap == exp_op, "R3", "opcode shifted", op_cap, exp_op);
  end
  always @(negedge spi_sclk) begin
    if (hi_min == 0 || cyc - hi_t < hi_min) hi_min = cyc - hi_t;
    if (cyc - hi_t > hi_max) hi_max = cyc - hi_t;
    spi_miso = bit_at(rise_n);
  end

  // monitor: scoreboard pop on every done
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      done_cnt++;
      done_cyc = cyc;
      check(!busy, "R12", "busy low at done", busy, 0);
      if (exp_q.size() == 0) begin
        check(0, "R12", "unexpected done", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check(result == e.res, e.tag, "result", result, e.res);
        check(match_flag == e.flag, e.tag, "match_flag", match_flag, e.flag);
        check(reads_cnt >= e.minr && reads_cnt <= e.maxr, e.tag, "read count", reads_cnt, e.minr);
        if (e.chk_st) check(status_out == e.st, e.tag, "status_out", status_out, e.st);
      end
    end
  end

  task automatic run(input logic [7:0] op, input logic [1:0] len, input logic dir,
                     input logic [15:0] mask, input logic [15:0] mat, input int init,
                     input int intv, input int tmo, input int half, input logic astop,
                     input exp_t e);
    @(negedge clk);
    cfg_opcode = op; cfg_len = len; cfg_dir_in = dir; cfg_mask = mask; cfg_match = mat;
    cfg_init_dly = CW'(init); cfg_interval = CW'(intv); cfg_timeout = CW'(tmo);
    cfg_half_div = DIVW'(half); cfg_auto_stop = astop;
    exp_op = op; dev_len = int'(len);
    reads_cnt = 0; min_gap = 0; hi_min = 0; hi_max = 0;
    exp_q.push_back(e);
    start_cyc = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mk(output exp_t e, input logic [1:0] r, input bit c, input logic [15:0] s,
                    input logic f, input int mn, input int mx, input string t);
    e.res = r; e.chk_st = c; e.st = s; e.flag = f; e.minr = mn; e.maxr = mx; e.tag = t;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual no end, expected run completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_t e;
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "bus idle in reset", {spi_cs_n, spi_sclk}, 2'b10);
    check(!busy && !done && !match_flag && !irq, "R1", "status low in reset",
          {busy, done, match_flag, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(spi_cs_n == 1'b1 && !busy, "R1", "idle after reset", {spi_cs_n, busy}, 2'b10);

    // R2 invalid configurations
    d0 = done_cnt; mk(e, 2'd2, 0, 0, 0, 0, 0, "R2");
    run(8'h05, 2'd0, 1'b1, 16'h1, 16'h0, 0, 0, 50, 1, 1'b1, e); wait_done(d0);
    d0 = done_cnt; mk(e, 2'd2, 0, 0, 0, 0, 0, "R2");
    run(8'h05, 2'd3, 1'b1, 16'h1, 16'h0, 0, 0, 50, 1, 1'b1, e); wait_done(d0);
    d0 = done_cnt; mk(e, 2'd2, 0, 0, 0, 0, 0, "R2");
    run(8'h05, 2'd1, 1'b0, 16'h1, 16'h0, 0, 0, 50, 1, 1'b1, e); wait_done(d0);

    // R3/R4 two-byte ordering, auto stop on third read
    resp_q = '{16'h0013, 16'h1301, 16'h1300};
    d0 = done_cnt; mk(e, 2'd0, 1, 16'h1300, 1, 3, 3, "R4");
    run(8'h05, 2'd2, 1'b1, 16'hFF01, 16'h1300, 5, 3, 2000, 1, 1'b1, e); wait_done(d0);
    check(first_fall >= longint'(5 * TICK_DIV), "R5", "initial delay", first_fall, 5 * TICK_DIV);
    check(min_gap >= longint'(2 + 2 * TICK_DIV), "R6", "gap between reads", min_gap, 2 + 2 * TICK_DIV);
    irq_en = 1'b1; #1;
    check(irq == 1'b1, "R10", "irq with flag and enable", irq, 1);
    irq_en = 1'b0; #1;
    check(irq == 1'b0, "R10", "irq masked", irq, 0);

    // R3 one-byte status, half period 3, flag still set from before (R9)
    resp_q = '{16'hAB01, 16'h0001, 16'hFF00};
    d0 = done_cnt; mk(e, 2'd0, 1, 16'h0000, 1, 3, 3, "R3");
    run(8'h0F, 2'd1, 1'b1, 16'h0001, 16'h0000, 0, 1, 2000, 3, 1'b1, e); wait_done(d0);
    check(hi_min == 3 && hi_max == 3, "R13", "sclk high width", hi_max, 3);

    // R9 clear
    match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;
    check(match_flag == 1'b0, "R9", "flag cleared", match_flag, 0);
    irq_en = 1'b1; #1;
    check(irq == 1'b0, "R10", "irq low with flag clear", irq, 0);
    irq_en = 1'b0;

    // R7 timeout
    dflt_resp = 16'h0001;
    d0 = done_cnt; mk(e, 2'd1, 1, 16'h0001, 0, 1, 100, "R7");
    run(8'h05, 2'd1, 1'b1, 16'h0001, 16'h0000, 0, 2, 60, 1, 1'b1, e); wait_done(d0);
    check(done_cyc - start_cyc >= longint'(60 * TICK_DIV), "R7", "timeout not early",
          done_cyc - start_cyc, 60 * TICK_DIV);

    // R8 continue after match
    resp_q = '{16'h0001, 16'h0000};
    d0 = done_cnt; mk(e, 2'd0, 1, 16'h0001, 1, 3, 1000, "R8");
    run(8'h05, 2'd1, 1'b1, 16'h0001, 16'h0000, 0, 2, 100, 1, 1'b0, e); wait_done(d0);
    match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;

    // R11 fault during second read
    d0 = done_cnt; mk(e, 2'd3, 0, 0, 0, 2, 2, "R11");
    run(8'h05, 2'd1, 1'b1, 16'h0001, 16'h0000, 0, 1, 2000, 1, 1'b1, e);
    while (reads_cnt < 2) @(negedge clk);
    xfer_fault = 1'b1; @(negedge clk); xfer_fault = 1'b0;
    wait_done(d0);
    check(done_cyc - start_cyc < 400, "R11", "fault ends early", done_cyc - start_cyc, 400);

    // R12 start while busy ignored
    d0 = done_cnt; mk(e, 2'd1, 0, 0, 0, 1, 100, "R12");
    run(8'h05, 2'd1, 1'b1, 16'h0001, 16'h0000, 0, 2, 50, 1, 1'b1, e);
    repeat (30) @(negedge clk);
    cfg_opcode = 8'h99; cfg_len = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(d0);
    repeat (60) @(negedge clk);
    check(done_cnt == d0 + 1 && exp_q.size() == 0, "R12", "single done per run", done_cnt - d0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule